// File: doc/BRIEF.md
# Dual-Protocol 8-Bit Host Bus Port

This block connects an 8-bit microprocessor bus to the register file and memory request queue of a display controller. It accepts two bus disciplines on one set of pins, and a static mode input chooses between them. In strobe mode the two control pins are separate active-low read and write strobes. In enable mode the same pins become an enable clock and a read/write level. Every access is qualified by an active-low chip select. A single address bit marks each transferred byte as either a command byte or a parameter/data byte.

All bus pins pass through a synchroniser into the system clock domain. The block acts on the trailing edge of each qualified access. A write produces a one-cycle command-write or data-write pulse that carries the captured byte. Each data write also carries its position in the parameter sequence since the last command. A read drives the bus with either a status byte or a byte taken from the memory side. Decoding of the command set and the memory sequencer belong to neighbouring blocks.

Top module: `hostbus_port`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `cmd_wr`, `data_wr`, `data_rd` and `d_oe` are 0 and `param_idx` is 0.
- R2: With `bus_mode` = 0 (strobe mode), a write is the interval where `cs_n` = 0 and `strb_b` = 0. When it ends, exactly one pulse is produced: `cmd_wr` if `a0` was 1, or `data_wr` if `a0` was 0. `wr_byte` shows the byte that was on `d_in`.
- R3: With `bus_mode` = 1 (enable mode), `strb_a` is an active-high enable and `strb_b` is the direction (1 = read, 0 = write). A bus cycle exists only while `cs_n` = 0 and `strb_a` = 1 together, and the block acts when that pair ends.
- R4: Strobe or enable activity while `cs_n` = 1 produces no pulse and never raises `d_oe`.
- R5: At most one of `cmd_wr`, `data_wr`, `data_rd` is high in any cycle. Each pulse lasts exactly one clock cycle, and each bus cycle produces at most one pulse.
- R6: A command write resets the parameter counter, so the next data write reports `param_idx` = 0.
- R7: Each data write reports the current counter value on `param_idx` and then advances the counter by one. The counter saturates at 2^PARAM_W − 1.
- R8: A read with `a0` = 0 returns a status byte. Bit 7 of that byte equals `queue_busy` and bits 6..0 are 0. Such a read produces no `data_rd` pulse.
- R9: A read with `a0` = 1 returns `mem_rdata` on `d_out` and produces one `data_rd` pulse when it ends.
- R10: `d_oe` rises only during a chip-selected read and returns to 0 after the read ends. It stays 0 throughout writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_mode | input | 1 | Static protocol select: 0 strobe mode, 1 enable mode |
| cs_n | input | 1 | Active-low chip select |
| a0 | input | 1 | Byte type: 1 command, 0 parameter/data (on reads: 1 data, 0 status) |
| strb_a | input | 1 | Read strobe (active low) or enable clock (active high) |
| strb_b | input | 1 | Write strobe (active low) or direction level (1 read) |
| d_in | input | 8 | Data bus from the host |
| d_out | output | 8 | Data bus to the host |
| d_oe | output | 1 | Output enable for the data bus pads |
| queue_busy | input | 1 | Memory request queue is busy |
| mem_rdata | input | 8 | Byte from the memory side for data reads |
| cmd_wr | output | 1 | One-cycle command byte write pulse |
| data_wr | output | 1 | One-cycle parameter/data byte write pulse |
| wr_byte | output | 8 | Byte carried by the write pulses |
| param_idx | output | PARAM_W | Position of the data byte since the last command |
| data_rd | output | 1 | One-cycle data read pulse |

## Verification
Properties are evaluated on every cycle and cover three things. They check that the pulses are mutually exclusive and one cycle wide. They check that a command pulse coincides with a cleared counter. They check that each data pulse leaves the counter advanced or saturated. Only the bench's scenarios can show the rest. That includes the byte value and type captured in each protocol, and the fact that deselected activity is ignored. It also includes the content of the status and data bytes on reads, and when the output enable starts and stops. These are exercised through directed corner cases, such as counter saturation and a mode change between accesses, and through randomly mixed reads and writes in both modes.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic {
    MODE_STROBE = 1'b0,
    MODE_ENABLE = 1'b1
  } bus_mode_e;

  typedef struct packed {
    logic rd;
    logic wr;
  } bus_act_t;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= RST_VAL;
        else     chain[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= RST_VAL;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hb_decode.sv
module hb_decode
  import hb_pkg::*;
(
  input  bus_mode_e mode,
  input  logic      cs_n,
  input  logic      strb_a,
  input  logic      strb_b,
  output bus_act_t  act
);
  always_comb begin
    act = '0;
    if (!cs_n) begin
      unique case (mode)
        MODE_STROBE: begin
          act.rd = ~strb_a;
          act.wr = ~strb_b & strb_a;
        end
        MODE_ENABLE: begin
          act.rd = strb_a &  strb_b;
          act.wr = strb_a & ~strb_b;
        end
        default: act = '0;
      endcase
    end
  end
endmodule

// File: rtl/hb_xfer.sv
module hb_xfer
  import hb_pkg::*;
#(
  parameter int DW      = 8,
  parameter int PARAM_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  bus_act_t           act,
  input  logic               a0,
  input  logic [DW-1:0]      din,
  input  logic               queue_busy,
  input  logic [DW-1:0]      mem_rdata,
  output logic               cmd_wr,
  output logic               data_wr,
  output logic [DW-1:0]      wr_byte,
  output logic [PARAM_W-1:0] param_idx,
  output logic               data_rd,
  output logic [DW-1:0]      d_out,
  output logic               d_oe
);
  localparam logic [PARAM_W-1:0] CNT_MAX = {PARAM_W{1'b1}};

  logic               prev_wr, prev_rd;
  logic               a0_lat;
  logic [DW-1:0]      din_lat;
  logic [PARAM_W-1:0] cnt;
  logic               wr_end, rd_end;
  logic [DW-1:0]      status;

  assign wr_end = prev_wr & ~act.wr;
  assign rd_end = prev_rd & ~act.rd;
  assign status = {queue_busy, {(DW-1){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_wr   <= 1'b0;
      prev_rd   <= 1'b0;
      a0_lat    <= 1'b0;
      din_lat   <= '0;
      cnt       <= '0;
      cmd_wr    <= 1'b0;
      data_wr   <= 1'b0;
      data_rd   <= 1'b0;
      wr_byte   <= '0;
      param_idx <= '0;
      d_out     <= '0;
      d_oe      <= 1'b0;
    end else begin
      prev_wr <= act.wr;
      prev_rd <= act.rd;
      if (act.wr || act.rd) a0_lat  <= a0;
      if (act.wr)           din_lat <= din;

      cmd_wr  <= wr_end &  a0_lat;
      data_wr <= wr_end & ~a0_lat;
      data_rd <= rd_end &  a0_lat;

      if (wr_end) wr_byte <= din_lat;

      if (wr_end && a0_lat) begin
        cnt <= '0;
      end else if (wr_end) begin
        param_idx <= cnt;
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end

      d_oe <= act.rd;
      if (act.rd) d_out <= a0 ? mem_rdata : status;
    end
  end

  a_r5_one_pulse: assert property (@(posedge clk) disable iff (rst)
    $countones({cmd_wr, data_wr, data_rd}) <= 1);

  a_r5_rd_one_cycle: assert property (@(posedge clk) disable iff (rst)
    data_rd |=> !data_rd);

  a_r5_wr_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr || data_wr) |=> !(cmd_wr || data_wr));

  a_r6_cmd_clears_cnt: assert property (@(posedge clk) disable iff (rst)
    cmd_wr |-> (cnt == '0));

  a_r7_cnt_advance: assert property (@(posedge clk) disable iff (rst)
    data_wr |-> ((cnt == param_idx + 1'b1) ||
                 (param_idx == CNT_MAX && cnt == CNT_MAX)));
endmodule

// File: rtl/hostbus_port.sv
module hostbus_port #(
  parameter int DW          = 8,
  parameter int PARAM_W     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_mode,
  input  logic               cs_n,
  input  logic               a0,
  input  logic               strb_a,
  input  logic               strb_b,
  input  logic [DW-1:0]      d_in,
  output logic [DW-1:0]      d_out,
  output logic               d_oe,
  input  logic               queue_busy,
  input  logic [DW-1:0]      mem_rdata,
  output logic               cmd_wr,
  output logic               data_wr,
  output logic [DW-1:0]      wr_byte,
  output logic [PARAM_W-1:0] param_idx,
  output logic               data_rd
);
  import hb_pkg::*;

  localparam int SW = DW + 5;
  localparam logic [SW-1:0] SYNC_RST = {1'b0, 1'b1, 1'b0, 1'b1, 1'b1, {DW{1'b0}}};

  logic [SW-1:0] raw_bus, syn_bus;
  logic          mode_s, cs_n_s, a0_s, strb_a_s, strb_b_s;
  logic [DW-1:0] din_s;
  bus_act_t      act;

  assign raw_bus = {bus_mode, cs_n, a0, strb_a, strb_b, d_in};

  hb_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_bus),
    .q   (syn_bus)
  );

  assign {mode_s, cs_n_s, a0_s, strb_a_s, strb_b_s, din_s} = syn_bus;

  hb_decode u_dec (
    .mode   (bus_mode_e'(mode_s)),
    .cs_n   (cs_n_s),
    .strb_a (strb_a_s),
    .strb_b (strb_b_s),
    .act    (act)
  );

  hb_xfer #(.DW(DW), .PARAM_W(PARAM_W)) u_xfer (
    .clk        (clk),
    .rst        (rst),
    .act        (act),
    .a0         (a0_s),
    .din        (din_s),
    .queue_busy (queue_busy),
    .mem_rdata  (mem_rdata),
    .cmd_wr     (cmd_wr),
    .data_wr    (data_wr),
    .wr_byte    (wr_byte),
    .param_idx  (param_idx),
    .data_rd    (data_rd),
    .d_out      (d_out),
    .d_oe       (d_oe)
  );

  a_r10_oe_needs_cs: assert property (@(posedge clk) disable iff (rst)
    $rose(d_oe) |-> !$past(cs_n_s));
endmodule

// File: tb/tb_hostbus_port.sv
module tb_hostbus_port;
  localparam int DW = 8;
  localparam int PW = 4;
  localparam logic [PW-1:0] MAXC = {PW{1'b1}};

  logic clk = 0, rst = 1;
  logic bus_mode = 0, cs_n = 1, a0 = 0, strb_a = 1, strb_b = 1;
  logic [DW-1:0] d_in = '0, mem_rdata = '0;
  logic queue_busy = 0;
  logic [DW-1:0] d_out, wr_byte;
  logic d_oe, cmd_wr, data_wr, data_rd;
  logic [PW-1:0] param_idx;

  always #2 clk = ~clk;

  hostbus_port #(.DW(DW), .PARAM_W(PW), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .bus_mode(bus_mode), .cs_n(cs_n), .a0(a0),
    .strb_a(strb_a), .strb_b(strb_b), .d_in(d_in), .d_out(d_out), .d_oe(d_oe),
    .queue_busy(queue_busy), .mem_rdata(mem_rdata), .cmd_wr(cmd_wr),
    .data_wr(data_wr), .wr_byte(wr_byte), .param_idx(param_idx), .data_rd(data_rd)
  );

  int n_tests = 0, n_fail = 0;
  int n_cmd = 0, n_data = 0, n_rd = 0;
  logic [DW-1:0] last_cmd = '0, last_data = '0;
  logic [PW-1:0] last_idx = '0;
  logic oe_seen = 0, multi = 0;
  logic [PW-1:0] exp_cnt = '0;
  bit done = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (cmd_wr)  begin n_cmd++;  last_cmd = wr_byte; end
      if (data_wr) begin n_data++; last_data = wr_byte; last_idx = param_idx; end
      if (data_rd) n_rd++;
      if (d_oe) oe_seen = 1;
      if (32'(cmd_wr) + 32'(data_wr) + 32'(data_rd) > 1) multi = 1;
    end
  end

  function automatic logic [DW-1:0] exp_status(input logic busy);
    return {busy, {(DW-1){1'b0}}};
  endfunction

  function automatic logic [PW-1:0] sat_inc(input logic [PW-1:0] c);
    return (c == MAXC) ? c : c + 1'b1;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk);
    cs_n = 1; bus_mode = m; strb_a = m ? 1'b0 : 1'b1; strb_b = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic bus_cycle(input logic is_rd, input logic a0v, input logic [DW-1:0] dv,
                           input logic sel_n, input int hold, output logic [DW-1:0] seen);
    @(negedge clk);
    a0 = a0v; d_in = dv; cs_n = sel_n;
    if (bus_mode) strb_b = is_rd;
    @(negedge clk);
    if (bus_mode) strb_a = 1;
    else if (is_rd) strb_a = 0;
    else strb_b = 0;
    repeat (hold) @(negedge clk);
    seen = d_out;
    if (bus_mode) strb_a = 0;
    else begin strb_a = 1; strb_b = 1; end
    @(negedge clk);
    cs_n = 1;
    repeat (8) @(negedge clk);
  endtask

  task automatic do_write(input logic a0v, input logic [DW-1:0] dv, input string req);
    int bc, bd, br;
    logic [DW-1:0] s;
    bc = n_cmd; bd = n_data; br = n_rd; oe_seen = 0;
    bus_cycle(1'b0, a0v, dv, 1'b0, 3 + $urandom_range(0, 3), s);
    if (a0v) begin
      check(n_cmd == bc + 1 && n_data == bd, req, n_cmd - bc, 1);
      check(last_cmd == dv, req, last_cmd, dv);
      exp_cnt = '0;
    end else begin
      check(n_data == bd + 1 && n_cmd == bc, req, n_data - bd, 1);
      check(last_data == dv, req, last_data, dv);
      check(last_idx == exp_cnt, "R7 param index", last_idx, exp_cnt);
      exp_cnt = sat_inc(exp_cnt);
    end
    check(n_rd == br && !oe_seen, "R10 no drive on write", int'(oe_seen), 0);
    check(!multi, "R5 single pulse", int'(multi), 0);
  endtask

  task automatic do_read(input logic a0v, input logic busy, input logic [DW-1:0] mv,
                         input string req);
    int bc, bd, br;
    logic [DW-1:0] s, e;
    bc = n_cmd; bd = n_data; br = n_rd; oe_seen = 0;
    queue_busy = busy; mem_rdata = mv;
    bus_cycle(1'b1, a0v, $urandom_range(0, 255), 1'b0, 4 + $urandom_range(0, 3), s);
    e = a0v ? mv : exp_status(busy);
    check(s == e, req, s, e);
    check(n_rd == br + int'(a0v) && n_cmd == bc && n_data == bd, req, n_rd - br, int'(a0v));
    check(oe_seen && !d_oe, "R10 oe during read only", int'(d_oe), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] s;
    int bc, bd, br;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    check(!cmd_wr && !data_wr && !data_rd && !d_oe && param_idx == '0,
          "R1 reset", int'({cmd_wr, data_wr, data_rd, d_oe}), 0);
    rst = 0;
    @(negedge clk);
    check(!cmd_wr && !data_wr && !data_rd && !d_oe && param_idx == '0,
          "R1 after release", int'({cmd_wr, data_wr, data_rd, d_oe}), 0);

    // R2: strobe mode, command then data
    set_mode(1'b0);
    do_write(1'b1, 8'h4C, "R2 cmd write");
    do_write(1'b0, 8'hA5, "R2 data write");
    do_write(1'b0, 8'h00, "R2 data write zero");
    do_write(1'b0, 8'hFF, "R2 data write ones");
    // R6: command clears counter
    do_write(1'b1, 8'h81, "R6 cmd");
    do_write(1'b0, 8'h12, "R6 first param");
    // R8, R9 in strobe mode
    do_read(1'b0, 1'b1, 8'h3C, "R8 status busy");
    do_read(1'b0, 1'b0, 8'h3C, "R8 status idle");
    do_read(1'b1, 1'b0, 8'hC3, "R9 data read");

    // R4: deselected activity in both modes
    bc = n_cmd; bd = n_data; br = n_rd; oe_seen = 0;
    bus_cycle(1'b0, 1'b1, 8'h55, 1'b1, 4, s);
    bus_cycle(1'b1, 1'b1, 8'h55, 1'b1, 4, s);
    set_mode(1'b1);
    bus_cycle(1'b0, 1'b0, 8'h66, 1'b1, 4, s);
    bus_cycle(1'b1, 1'b1, 8'h66, 1'b1, 4, s);
    check(n_cmd == bc && n_data == bd && n_rd == br, "R4 deselected no pulse",
          n_cmd + n_data + n_rd - bc - bd - br, 0);
    check(!oe_seen, "R4 deselected no drive", int'(oe_seen), 0);

    // R3: enable mode
    do_write(1'b1, 8'h5A, "R3 cmd write");
    do_write(1'b0, 8'h37, "R3 data write");
    do_read(1'b1, 1'b1, 8'h9E, "R3 data read");
    do_read(1'b0, 1'b1, 8'h00, "R3 status read");

    // R7: saturation
    do_write(1'b1, 8'h40, "R7 cmd");
    for (int i = 0; i < int'(MAXC) + 4; i++) do_write(1'b0, 8'(i * 7 + 1), "R7 data");
    check(last_idx == MAXC, "R7 saturated", last_idx, MAXC);

    // Random mix across both modes
    for (int k = 0; k < 150; k++) begin
      if ($urandom_range(0, 9) == 0) set_mode(bus_mode ^ 1'b1);
      case ($urandom_range(0, 3))
        0: do_write(1'b1, 8'($urandom_range(0, 255)), "R2 R3 rand cmd");
        1: do_write(1'b0, 8'($urandom_range(0, 255)), "R2 R3 rand data");
        2: do_read(1'b0, 1'($urandom_range(0, 1)), 8'($urandom_range(0, 255)), "R8 rand status");
        default: do_read(1'b1, 1'b0, 8'($urandom_range(0, 255)), "R9 rand data read");
      endcase
    end

    check(!multi, "R5 final", int'(multi), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule